// File: doc/BRIEF.md
# Pitch Divider for a Walsh Voice

This block derives the octave-spaced square waves that a Walsh-function voice needs from a fast reference clock. A host writes a 16-bit divisor as two byte writes. The divisor packs three fields: an 11-bit integer pitch factor, a 3-bit octave exponent and a 2-bit bypass code. The reference is divided first by the pitch factor in a reloading down-counter. It is then divided by a power of two in a prescaler. The result clocks a synchronous chain of six toggle stages.

Only whole-number division is used, so every square-wave edge lands on a reference edge at a fixed spacing and the duty cycle stays exactly one half. The bypass code removes up to two divide-by-two stages. This reaches the highest octaves without a faster reference. A newly written divisor is applied only at the next reload of the pitch counter, so a count in progress always finishes with the value it started with.

Top module: `note_divider`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all six square outputs are 0.
- R2: The divisor is D = {upper byte, lower byte}. The pitch factor is D[10:0], so upper byte bits [2:0] are its bits [10:8]. With octave code D[13:11] = 0 and bypass code D[15:14] = 0, `sq_o[5]` changes level every N reference cycles, where N is the pitch factor.
- R3: A pitch factor of 0 or 1 acts as division by 1: `sq_o[5]` changes level on every reference cycle, and the pitch counter never holds 0.
- R4: Octave code o (D[13:11]) multiplies the half-period of `sq_o[5]` by 2^o for o up to 6. Codes 6 and 7 both give a factor of 64.
- R5: Bypass code s (D[15:14]) removes s divide-by-two stages for s = 0, 1 or 2. Code 3 acts as 2. The effective exponent is max(min(o,6) - min(s,2), 0).
- R6: `sq_o[k]` has twice the period of `sq_o[k+1]`. Each output changes only in a cycle where the next faster output falls.
- R7: A divisor written while a pitch count is running takes effect only at the next reload. The interval in progress completes with the old factor.
- R8: Writing one byte of the divisor leaves the other byte unchanged.
- R9: In any cycle, at most one square output goes from 0 to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock; all state advances on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_lo_i | input | 1 | Write strobe for the lower divisor byte |
| wr_hi_i | input | 1 | Write strobe for the upper divisor byte |
| wr_data_i | input | 8 | Byte written by either strobe |
| sq_o | output | 6 | Square waves; `sq_o[k]` runs at 2^k times the fundamental |

## Verification
On every cycle, the assertions check the binary relation between neighbouring outputs and the rule that at most one output rises per cycle. They also check that the pitch counter never reaches zero and that the applied divisor changes only at a reload. The exact half-periods for given pitch, octave and bypass values can only be shown by the bench's scenarios, which time output edges against computed expectations. The same holds for the clamping of octave and bypass codes, for partial byte updates and for the deferral of a mid-count write.

// File: rtl/note_divider_pkg.sv
package note_divider_pkg;

    localparam int SEMI_W   = 11;
    localparam int OCT_W    = 3;
    localparam int SKIP_W   = 2;
    localparam int STAGES   = 6;
    localparam int MAX_EXP  = 6;
    localparam int MAX_SKIP = 2;
    localparam int EXP_W    = OCT_W;
    localparam int PRE_W    = MAX_EXP;
    localparam int DIV_W    = SEMI_W + OCT_W + SKIP_W;

    // Field order matches the byte layout: {skip, octave, pitch}
    typedef struct packed {
        logic [SKIP_W-1:0] skip;
        logic [OCT_W-1:0]  oct;
        logic [SEMI_W-1:0] semi;
    } divisor_t;

    function automatic logic [EXP_W-1:0] eff_exp(input divisor_t d);
        logic [EXP_W-1:0] o;
        logic [EXP_W-1:0] s;
        o = (int'(d.oct) > MAX_EXP) ? EXP_W'(MAX_EXP) : d.oct;
        s = (int'(d.skip) > MAX_SKIP) ? EXP_W'(MAX_SKIP) : EXP_W'(d.skip);
        return (o > s) ? (o - s) : '0;
    endfunction

    function automatic logic [SEMI_W-1:0] eff_count(input divisor_t d);
        return (d.semi <= SEMI_W'(1)) ? SEMI_W'(1) : d.semi;
    endfunction

endpackage

// File: rtl/divisor_regs.sv
module divisor_regs
    import note_divider_pkg::*;
(
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           wr_lo_i,
    input  logic           wr_hi_i,
    input  logic [7:0]     wr_data_i,
    output divisor_t       pending_o
);
    logic [DIV_W-1:0] word_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            word_q <= '0;
        end else begin
            if (wr_lo_i) word_q[7:0]       <= wr_data_i;
            if (wr_hi_i) word_q[DIV_W-1:8] <= wr_data_i;
        end
    end

    assign pending_o = divisor_t'(word_q);
endmodule

// File: rtl/pitch_counter.sv
module pitch_counter
    import note_divider_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  divisor_t          pending_i,
    output logic              pulse_o,
    output divisor_t          active_o,
    output logic [SEMI_W-1:0] count_o
);
    logic [SEMI_W-1:0] cnt_q;
    divisor_t          active_q;

    assign pulse_o = (cnt_q == SEMI_W'(1));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q    <= SEMI_W'(1);
            active_q <= '0;
        end else if (pulse_o) begin
            cnt_q    <= eff_count(pending_i);
            active_q <= pending_i;
        end else begin
            cnt_q    <= cnt_q - SEMI_W'(1);
        end
    end

    assign active_o = active_q;
    assign count_o  = cnt_q;
endmodule

// File: rtl/octave_prescale.sv
module octave_prescale
    import note_divider_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             pulse_i,
    input  logic [EXP_W-1:0] exp_i,
    output logic             tick_o
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    assign mask   = PRE_W'((32'd1 << exp_i) - 32'd1);
    assign tick_o = pulse_i && ((pre_q & mask) == mask);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pre_q <= '0;
        end else if (pulse_i) begin
            pre_q <= tick_o ? '0 : pre_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/toggle_chain.sv
module toggle_chain
    import note_divider_pkg::*;
#(
    parameter int N = STAGES
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         tick_i,
    output logic [N-1:0] sq_o
);
    logic [N-1:0] t_q;
    logic [N:0]   carry;

    assign carry[0] = tick_i;

    for (genvar j = 0; j < N; j++) begin : g_stage
        assign carry[j+1] = carry[j] & t_q[j];

        always_ff @(posedge clk_i) begin
            if (rst_i)         t_q[j] <= 1'b0;
            else if (carry[j]) t_q[j] <= ~t_q[j];
        end

        // fastest toggle drives the top output index
        assign sq_o[N-1-j] = t_q[j];
    end
endmodule

// File: rtl/note_divider.sv
module note_divider
    import note_divider_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_lo_i,
    input  logic              wr_hi_i,
    input  logic [7:0]        wr_data_i,
    output logic [STAGES-1:0] sq_o
);
    divisor_t          pending;
    divisor_t          active;
    logic              pulse;
    logic              tick;
    logic [SEMI_W-1:0] count;

    divisor_regs u_regs (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_lo_i   (wr_lo_i),
        .wr_hi_i   (wr_hi_i),
        .wr_data_i (wr_data_i),
        .pending_o (pending)
    );

    pitch_counter u_pitch (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .pending_i (pending),
        .pulse_o   (pulse),
        .active_o  (active),
        .count_o   (count)
    );

    octave_prescale u_pre (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .pulse_i (pulse),
        .exp_i   (eff_exp(active)),
        .tick_o  (tick)
    );

    toggle_chain #(.N(STAGES)) u_chain (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_i (tick),
        .sq_o   (sq_o)
    );
endmodule

// File: rtl/note_divider_checker.sv
module note_divider_checker
    import note_divider_pkg::*;
(
    input logic              clk_i,
    input logic              rst_i,
    input logic [STAGES-1:0] sq_o,
    input logic              pulse,
    input logic [DIV_W-1:0]  active,
    input logic [SEMI_W-1:0] count
);
    assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(rst_i) |-> (sq_o == '0));

    assert_count_nonzero_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        count != '0);

    for (genvar k = 0; k < STAGES - 1; k++) begin : g_pair
        assert_halving_R6: assert property (@(posedge clk_i) disable iff (rst_i)
            !$stable(sq_o[k]) |-> $fell(sq_o[k+1]));
    end

    assert_hold_until_reload_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !pulse |=> $stable(active));

    assert_single_rise_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        $countones(sq_o & ~$past(sq_o)) <= 1);
endmodule

bind note_divider note_divider_checker u_chk (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .sq_o   (sq_o),
    .pulse  (pulse),
    .active (active),
    .count  (count)
);

// File: tb/note_divider_tb.sv
module note_divider_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int GAP_LIMIT  = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_lo = 1'b0;
    logic       wr_hi = 1'b0;
    logic [7:0] wr_data = '0;
    logic [5:0] sq;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    note_divider dut_i (
        .clk_i     (clk),
        .rst_i     (rst),
        .wr_lo_i   (wr_lo),
        .wr_hi_i   (wr_hi),
        .wr_data_i (wr_data),
        .sq_o      (sq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // three negedges
    task automatic set_div(input logic [7:0] lo, input logic [7:0] hi);
        @(negedge clk); wr_lo = 1'b1; wr_data = lo;
        @(negedge clk); wr_lo = 1'b0; wr_hi = 1'b1; wr_data = hi;
        @(negedge clk); wr_hi = 1'b0;
    endtask

    task automatic wait_change(input int k, output int gap);
        logic prev;
        prev = sq[k];
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (sq[k] == prev && gap < GAP_LIMIT);
    endtask

    task automatic measure(input int k, input int exp_half, input string req);
        int gap;
        for (int s = 0; s < 3; s++) wait_change(k, gap);
        for (int r = 0; r < 3; r++) begin
            wait_change(k, gap);
            check(gap == exp_half, req, gap, exp_half);
        end
    endtask

    task automatic test_reset_R1();
        check(sq == 6'd0, "R1 outputs during reset", int'(sq), 0);
        @(negedge clk); rst = 1'b0;
        check(sq == 6'd0, "R1 outputs after release", int'(sq), 0);
    endtask

    task automatic test_min_factor_R3();
        measure(5, 1, "R3 factor 0");
        set_div(8'd1, 8'h00);
        measure(5, 1, "R3 factor 1");
    endtask

    task automatic test_pitch_R2();
        set_div(8'd239, 8'h00);
        measure(5, 239, "R2 factor 239");
        set_div(8'd195, 8'h01);
        measure(5, 451, "R2 factor 451");
        set_div(8'd7, 8'h00);
        measure(5, 7, "R2 factor 7");
    endtask

    task automatic test_octave_R4();
        set_div(8'd10, {2'd0, 3'd3, 3'd0});
        measure(5, 80, "R4 octave 3");
        set_div(8'd10, {2'd0, 3'd6, 3'd0});
        measure(5, 640, "R4 octave 6");
        set_div(8'd10, {2'd0, 3'd7, 3'd0});
        measure(5, 640, "R4 octave 7 clamps");
    endtask

    task automatic test_skip_R5();
        set_div(8'd10, {2'd1, 3'd3, 3'd0});
        measure(5, 40, "R5 skip 1");
        set_div(8'd10, {2'd2, 3'd3, 3'd0});
        measure(5, 20, "R5 skip 2");
        set_div(8'd10, {2'd3, 3'd3, 3'd0});
        measure(5, 20, "R5 skip 3 as 2");
        set_div(8'd10, {2'd2, 3'd1, 3'd0});
        measure(5, 10, "R5 skip floors at 0");
        set_div(8'd10, {2'd1, 3'd7, 3'd0});
        measure(5, 320, "R5 skip with clamped octave");
    endtask

    task automatic test_chain_R6();
        set_div(8'd3, 8'h00);
        measure(4, 6, "R6 output 4");
        measure(2, 24, "R6 output 2");
        measure(0, 96, "R6 output 0");
    endtask

    task automatic test_partial_R8();
        set_div(8'd100, 8'h00);
        measure(5, 100, "R8 base");
        @(negedge clk); wr_hi = 1'b1; wr_data = {2'd0, 3'd1, 3'd0};
        @(negedge clk); wr_hi = 1'b0;
        measure(5, 200, "R8 upper write keeps lower");
        @(negedge clk); wr_lo = 1'b1; wr_data = 8'd50;
        @(negedge clk); wr_lo = 1'b0;
        measure(5, 100, "R8 lower write keeps upper");
    endtask

    task automatic test_deferred_R7();
        int gap;
        set_div(8'd144, 8'h01);          // 400
        measure(5, 400, "R7 old factor");
        wait_change(5, gap);             // just after a reload
        set_div(8'd50, 8'h00);
        wait_change(5, gap);
        check(gap + 3 == 400, "R7 running interval keeps old factor", gap + 3, 400);
        wait_change(5, gap);
        check(gap == 50, "R7 new factor after reload", gap, 50);
    endtask

    task automatic test_rise_R9();
        int rises;
        logic [5:0] prev;
        set_div(8'd1, 8'h00);
        prev = sq;
        rises = 0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if ($countones(sq & ~prev) > 1) rises++;
            prev = sq;
        end
        check(rises == 0, "R9 multiple rises in one cycle", rises, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset_R1();
        test_min_factor_R3();
        test_pitch_R2();
        test_octave_R4();
        test_skip_R5();
        test_chain_R6();
        test_partial_R8();
        test_deferred_R7();
        test_rise_R9();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule